// File: doc/BRIEF.md
# Sync-Tip Clamp Level Regulator

This block holds the black level of digitised video in place. An upstream detector marks the sync tip with a gate. While the gate is open, the block gathers the 8-bit converter codes. When the gate closes, it judges whether the average tip code sits above or below a fixed target of 4. It then nudges a 10-bit clamp control word by one step. That word drives an analog clamp, either through a PWM or through a DAC. Over many lines, this closed loop moves the DC level of the input until the sync tip digitises at the target code.

Only cycles with the clock enable high count. Samples are added into a running sum, and the block keeps at most a parameterised number of them per gate. The decision multiplies the sample count by the two deadband limits and compares the sum against those products, so no divider is needed. The block raises a one-cycle up or down indication together with each correction request.

Top module: `sync_tip_clamp`

## Requirements
- R1: After reset, clamp_word is 512 (mid-scale of 10 bits) and step_up and step_dn are 0.
- R2: clamp_word changes only in the clock cycle that follows a gate close. A gate close is an enabled cycle with tip_gate low that comes after at least one enabled cycle with tip_gate high.
- R3: Let N be the number of samples in a gate and S their sum. If S < 3*N (average below target minus one), the close raises step_up for one cycle and clamp_word increases by 1.
- R4: If S > 5*N (average above target plus one), the close raises step_dn for one cycle and clamp_word decreases by 1.
- R5: If 3*N <= S <= 5*N, the close leaves clamp_word unchanged and raises neither indication.
- R6: clamp_word saturates at 1023 and at 0 and never wraps. At a limit, the indication still reports the requested direction.
- R7: A cycle with ce low is ignored. Its code is not accumulated, and its tip_gate value neither opens nor closes a gate.
- R8: Only the first 64 enabled samples of a gate enter the sum. Later samples in the same gate are discarded.
- R9: A gate of any length changes clamp_word by at most one step.
- R10: step_up and step_dn are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable qualifying each sample |
| tip_gate | input | 1 | High during the sync tip |
| adc_code | input | 8 | Converter output code |
| clamp_word | output | 10 | Clamp level control word |
| step_up | output | 1 | One-cycle pulse: clamp word raised (or requested at the top limit) |
| step_dn | output | 1 | One-cycle pulse: clamp word lowered (or requested at the bottom limit) |

## Verification
The bench sweeps every constant tip code through a gate. It also drives code pairs whose average lands exactly on the deadband edges (3 and 5) and just beyond them. A design that used a strict or inclusive compare on the wrong side would step there when it should hold, or hold when it should step. Gates padded with disabled cycles carrying extreme codes would expose a design that ignores ce, because it would step the wrong way. An over-long gate whose late samples oppose the early ones would expose a missing sample cap in the same way. The bench also drives the word to both rails and beyond them, which catches wrap-around, and runs a long gate to catch per-sample stepping.

// File: rtl/clamp_reg_pkg.sv
package clamp_reg_pkg;

    localparam int CODE_W      = 8;
    localparam int WORD_W      = 10;
    localparam int TARGET      = 4;
    localparam int DEADBAND    = 1;
    localparam int MAX_SAMPLES = 64;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

endpackage

// File: rtl/tip_accum.sv
module tip_accum
    import clamp_reg_pkg::*;
#(
    parameter int CODE_W_P    = CODE_W,
    parameter int MAX_SAMP_P  = MAX_SAMPLES,
    localparam int CNT_W      = $clog2(MAX_SAMP_P + 1),
    localparam int SUM_W      = CODE_W_P + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              gate,
    input  logic [CODE_W_P-1:0] code,
    output logic [SUM_W-1:0]  sum,
    output logic [CNT_W-1:0]  cnt,
    output logic              close
);

    typedef struct packed {
        logic             active;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
    } acc_t;

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_SAMP_P);

    acc_t acc_d, acc_q;
    logic close_c;

    always_comb begin
        acc_d   = acc_q;
        close_c = ce && !gate && acc_q.active;
        if (ce) begin
            if (gate) begin
                acc_d.active = 1'b1;
                if (acc_q.cnt < CNT_LIMIT) begin
                    acc_d.sum = acc_q.sum + SUM_W'(code);
                    acc_d.cnt = acc_q.cnt + 1'b1;
                end
            end else begin
                acc_d.active = 1'b0;
                acc_d.sum    = '0;
                acc_d.cnt    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sum   = acc_q.sum;
    assign cnt   = acc_q.cnt;
    assign close = close_c;

endmodule

// File: rtl/tip_decide.sv
module tip_decide
    import clamp_reg_pkg::*;
#(
    parameter int SUM_W_P    = 15,
    parameter int CNT_W_P    = 7,
    parameter int TARGET_P   = TARGET,
    parameter int DEADBAND_P = DEADBAND,
    localparam int PROD_W    = SUM_W_P + 4
) (
    input  logic [SUM_W_P-1:0] sum,
    input  logic [CNT_W_P-1:0] cnt,
    input  logic               close,
    output dir_e               dir
);

    localparam logic [PROD_W-1:0] HI_K = PROD_W'(TARGET_P + DEADBAND_P);
    localparam logic [PROD_W-1:0] LO_K = PROD_W'(TARGET_P - DEADBAND_P);

    logic [PROD_W-1:0] sum_x;
    logic [PROD_W-1:0] hi_lim;
    logic [PROD_W-1:0] lo_lim;

    always_comb begin
        sum_x  = PROD_W'(sum);
        hi_lim = PROD_W'(cnt) * HI_K;
        lo_lim = PROD_W'(cnt) * LO_K;
        dir    = DIR_HOLD;
        if (close) begin
            if (sum_x > hi_lim) begin
                dir = DIR_DOWN;
            end else if (sum_x < lo_lim) begin
                dir = DIR_UP;
            end
        end
    end

endmodule

// File: rtl/clamp_integrator.sv
module clamp_integrator
    import clamp_reg_pkg::*;
#(
    parameter int WORD_W_P = WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  dir_e                dir,
    output logic [WORD_W_P-1:0] word,
    output logic                up,
    output logic                dn
);

    localparam logic [WORD_W_P-1:0] WORD_MAX = {WORD_W_P{1'b1}};
    localparam logic [WORD_W_P-1:0] WORD_MIN = '0;
    localparam logic [WORD_W_P-1:0] WORD_MID = WORD_W_P'(1) << (WORD_W_P - 1);

    typedef struct packed {
        logic [WORD_W_P-1:0] word;
        logic                up;
        logic                dn;
    } integ_t;

    integ_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.up = 1'b0;
        st_d.dn = 1'b0;
        unique case (dir)
            DIR_UP: begin
                st_d.up = 1'b1;
                if (st_q.word != WORD_MAX) begin
                    st_d.word = st_q.word + 1'b1;
                end
            end
            DIR_DOWN: begin
                st_d.dn = 1'b1;
                if (st_q.word != WORD_MIN) begin
                    st_d.word = st_q.word - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= WORD_MID;
            st_q.up   <= 1'b0;
            st_q.dn   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign up   = st_q.up;
    assign dn   = st_q.dn;

endmodule

// File: rtl/sync_tip_clamp.sv
module sync_tip_clamp
    import clamp_reg_pkg::*;
#(
    parameter int CODE_W_P    = CODE_W,
    parameter int WORD_W_P    = WORD_W,
    parameter int TARGET_P    = TARGET,
    parameter int DEADBAND_P  = DEADBAND,
    parameter int MAX_SAMP_P  = MAX_SAMPLES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  logic                tip_gate,
    input  logic [CODE_W_P-1:0] adc_code,
    output logic [WORD_W_P-1:0] clamp_word,
    output logic                step_up,
    output logic                step_dn
);

    localparam int CNT_W = $clog2(MAX_SAMP_P + 1);
    localparam int SUM_W = CODE_W_P + CNT_W;

    logic [SUM_W-1:0] acc_sum;
    logic [CNT_W-1:0] acc_cnt;
    logic             gate_close;
    dir_e             step_dir;

    tip_accum #(
        .CODE_W_P   (CODE_W_P),
        .MAX_SAMP_P (MAX_SAMP_P)
    ) accum_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .gate  (tip_gate),
        .code  (adc_code),
        .sum   (acc_sum),
        .cnt   (acc_cnt),
        .close (gate_close)
    );

    tip_decide #(
        .SUM_W_P    (SUM_W),
        .CNT_W_P    (CNT_W),
        .TARGET_P   (TARGET_P),
        .DEADBAND_P (DEADBAND_P)
    ) decide_i (
        .sum   (acc_sum),
        .cnt   (acc_cnt),
        .close (gate_close),
        .dir   (step_dir)
    );

    clamp_integrator #(
        .WORD_W_P (WORD_W_P)
    ) integ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .dir   (step_dir),
        .word  (clamp_word),
        .up    (step_up),
        .dn    (step_dn)
    );

endmodule

// File: rtl/sync_tip_clamp_chk.sv
module sync_tip_clamp_chk #(
    parameter int WORD_W_P = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [WORD_W_P-1:0] clamp_word,
    input logic                step_up,
    input logic                step_dn
);

    localparam logic [WORD_W_P-1:0] WMAX = {WORD_W_P{1'b1}};

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R10
    up_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> !step_up);

    // R10
    dn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |=> !step_dn);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_word != $past(clamp_word)) |-> (step_up || step_dn));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && $past(clamp_word) != WMAX) |-> (clamp_word == $past(clamp_word) + 1'b1));

    // R4
    dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && $past(clamp_word) != '0) |-> (clamp_word == $past(clamp_word) - 1'b1));

    // R6
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && $past(clamp_word) == WMAX) |-> (clamp_word == WMAX));

    // R6
    bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && $past(clamp_word) == '0) |-> (clamp_word == '0));

endmodule

bind sync_tip_clamp sync_tip_clamp_chk #(.WORD_W_P(WORD_W_P)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clamp_word (clamp_word),
    .step_up    (step_up),
    .step_dn    (step_dn)
);

// File: tb/sync_tip_clamp_tb_top.sv
`timescale 1ns/1ps
module sync_tip_clamp_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       tip_gate = 1'b0;
    logic [7:0] adc_code = 8'd0;
    logic [9:0] clamp_word;
    logic       step_up;
    logic       step_dn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_word = 512;
    int m_sum  = 0;
    int m_cnt  = 0;
    bit m_act  = 1'b0;

    always #5 clk = ~clk;

    sync_tip_clamp dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce),
        .tip_gate   (tip_gate),
        .adc_code   (adc_code),
        .clamp_word (clamp_word),
        .step_up    (step_up),
        .step_dn    (step_dn)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sample(input int c);
        @(negedge clk);
        tip_gate = 1'b1; ce = 1'b1; adc_code = 8'(c);
        m_act = 1'b1;
        if (m_cnt < 64) begin
            m_sum += c;
            m_cnt++;
        end
    endtask

    task automatic sample_noce(input int c, input bit g);
        @(negedge clk);
        tip_gate = g; ce = 1'b0; adc_code = 8'(c);
    endtask

    task automatic close_gate(input string tag);
        int eu = 0;
        int ed = 0;
        if (m_act) begin
            if (m_sum > m_cnt * 5) ed = 1;
            else if (m_sum < m_cnt * 3) eu = 1;
        end
        if (eu == 1 && m_word < 1023) m_word++;
        if (ed == 1 && m_word > 0) m_word--;
        @(negedge clk);
        tip_gate = 1'b0; ce = 1'b1;
        @(negedge clk);
        check({tag, " word"}, int'(clamp_word), m_word);
        check({tag, " up"}, int'(step_up), eu);
        check({tag, " dn"}, int'(step_dn), ed);
        @(negedge clk);
        check({tag, " R10 up clear"}, int'(step_up), 0);
        check({tag, " R10 dn clear"}, int'(step_dn), 0);
        check({tag, " R2 word stable"}, int'(clamp_word), m_word);
        m_sum = 0; m_cnt = 0; m_act = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset word", int'(clamp_word), 512);
        check("R1 reset up", int'(step_up), 0);
        check("R1 reset dn", int'(step_dn), 0);

        // R2: idle, gate low
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            tip_gate = 1'b0; ce = (i % 2) == 0; adc_code = 8'd255;
            @(negedge clk);
            check("R2 idle word", int'(clamp_word), m_word);
        end

        // R3 R4 R5: sweep of constant codes
        for (int c = 0; c < 256; c++) begin
            for (int k = 0; k < 3; k++) sample(c);
            if (c < 3) close_gate("R3 sweep");
            else if (c > 5) close_gate("R4 sweep");
            else close_gate("R5 sweep");
        end

        // R5 deadband edges
        sample(2); sample(4); close_gate("R5 avg3 edge");
        sample(6); sample(4); close_gate("R5 avg5 edge");
        sample(2); sample(3); close_gate("R3 below edge");
        sample(6); sample(5); close_gate("R4 above edge");

        // R7: disabled cycles carry extreme codes
        sample(0); sample_noce(255, 1'b1); sample_noce(255, 1'b0);
        sample(1); sample_noce(255, 1'b1);
        close_gate("R7 ce gaps");
        sample_noce(0, 1'b1); sample_noce(0, 1'b1);
        close_gate("R7 gate without ce");

        // R8: late samples beyond 64 ignored
        for (int i = 0; i < 64; i++) sample(0);
        for (int i = 0; i < 10; i++) sample(255);
        close_gate("R8 sample cap");

        // R9: long gate makes one step
        for (int i = 0; i < 200; i++) sample(0);
        close_gate("R9 long gate");

        // R6: top rail
        while (m_word < 1023) begin
            sample(0); close_gate("R6 climb");
        end
        for (int i = 0; i < 3; i++) begin
            sample(0); close_gate("R6 top hold");
        end
        // R6: bottom rail
        while (m_word > 0) begin
            sample(255); close_gate("R6 descend");
        end
        for (int i = 0; i < 3; i++) begin
            sample(255); close_gate("R6 bottom hold");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule